// File: doc/BRIEF.md
# Redundant-Supply ORing Switch Gate Controller

This block decides when the series ORing switch of a redundant power supply may conduct, so that current only leaves the unit and never flows back from a shared bus. It compares two digitized voltages. One is taken on the converter side of the switch and the other on the bus side. The switch may close once the converter side, raised by a selectable fraction of the nominal output voltage, is above the bus side. A set/reset latch holds the on/off state. Debounced evidence sets the latch. Three independent paths can clear it: masked fault flags, a debounced reverse-current comparator flag, and a global gate-disable bit. The clearing paths always win over the setting path.

The latch drives a push-pull gate output whose active level is programmable. It also drives a select line that moves the regulation sense point. The select line chooses the remote point while the switch conducts and falls back to the converter-side point otherwise. The block also registers a 3-bit level code and passes it on to the external reverse-current comparator.

Top module: `oring_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a debounced enable has occurred, the gate sits at its inactive level (`gate_o` equal to the inverse of `gate_pol`) and `sense_sel_o` is 0.
- R2: The enable margin is `(nominal_rd * K) >> 16`, with K chosen by `thr_sel` as 00→0, 01→328, 10→655, 11→1311. The enable condition is true when `supply_rd + margin > bus_rd`, where strict equality counts as false.
- R3: The enable condition must hold for DEB_N consecutive clock samples. The active gate level appears after the rising edge DEB_N+1 counted from the first qualifying sample. A single non-qualifying sample restarts the count.
- R4: A fault flag clears the switch when both `fault_flags[i]` and `fault_off_mask[i]` are 1. The gate is inactive from the next rising edge and stays inactive for as long as that combination holds. A flag whose mask bit is 0 has no effect.
- R5: When `rev_en` is 1 and `rev_trip` has been 1 for DEB_N consecutive samples, the switch turns off at the following edge. When `rev_en` is 0, `rev_trip` is ignored.
- R6: While `gate_dis` is 1, `gate_o` is inactive and `sense_sel_o` is 0 in the same cycle, and the latch is cleared at the next edge.
- R7: When the switch is on, `gate_o` equals `gate_pol`. When it is off, `gate_o` equals `~gate_pol`. A polarity change takes effect without a clock edge.
- R8: `sense_sel_o` is 1 (remote point) exactly while the switch is on and `gate_dis` is 0. Otherwise it is 0 (converter-side point).
- R9: If any clearing condition and the debounced enable are present at the same edge, the latch is cleared.
- R10: `rev_level_o` is `rev_level` delayed by one clock, and it resets to 0.
- R11: Once set, the latch stays on after the enable condition disappears, until a clearing path acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_rd | input | DATA_W | Converter-side voltage reading |
| bus_rd | input | DATA_W | Bus-side voltage reading |
| nominal_rd | input | DATA_W | Nominal output voltage, same scale |
| thr_sel | input | 2 | Enable margin select (0, 0.5, 1, 2 % of nominal) |
| rev_trip | input | 1 | Reverse-current comparator flag |
| rev_en | input | 1 | Enables the reverse-current path |
| rev_level | input | 3 | Comparator level code |
| rev_level_o | output | 3 | Registered level code to the comparator |
| fault_flags | input | FLT_W | Live fault flags |
| fault_off_mask | input | FLT_W | Per-flag "turn switch off" action |
| gate_dis | input | 1 | Global gate disable |
| gate_pol | input | 1 | 1: active-high gate, 0: active-low |
| gate_o | output | 1 | Gate drive |
| sense_sel_o | output | 1 | 1: remote sense point, 0: converter-side point |

## Verification
The assertions assume that the configuration inputs change only between clock edges. They also assume that `gate_pol` is not toggled in the same cycle as a fault observation. If it were, the "inactive level" check would compare against the new polarity. The bench drives every input on the falling edge and changes polarity only while the fault paths are idle. It also holds readings constant for whole debounce windows, so the debounce counts the assertions rely on stay well defined.

// File: rtl/ogc_pkg.sv
// Package: shared encodings and constants for the ORing gate controller.
// Assumes: margin factors are scaled by 2**MARGIN_FRAC.
package ogc_pkg;

    typedef enum logic [1:0] {
        MARGIN_NONE = 2'b00,
        MARGIN_HALF = 2'b01,
        MARGIN_ONE  = 2'b10,
        MARGIN_TWO  = 2'b11
    } margin_sel_e;

    localparam int MARGIN_FRAC = 16;
    localparam int K_HALF      = 328;
    localparam int K_ONE       = 655;
    localparam int K_TWO       = 1311;
    localparam int K_GROWTH    = 11;

endpackage

// File: rtl/ogc_margin.sv
// Module: ogc_margin
// Computes the enable margin as a fraction of nominal with shift-and-add
// constant multipliers, then drops the fraction bits. Purely combinational.
// Assumes: DATA_W >= 6 so the scaled result fits the output width.
module ogc_margin
    import ogc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] nominal,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] margin
);
    localparam int PW = DATA_W + K_GROWTH;

    logic [PW-1:0] n_ext;
    logic [PW-1:0] p_half;
    logic [PW-1:0] p_one;
    logic [PW-1:0] p_two;
    logic [PW-1:0] p_sel;

    // Widen the operand once so every shifted term shares one width.
    assign n_ext = PW'(nominal);

    // Constant 328 = 256 + 64 + 8.
    assign p_half = (n_ext << 8) + (n_ext << 6) + (n_ext << 3);

    // Constant 655 = 512 + 128 + 8 + 4 + 2 + 1.
    assign p_one = (n_ext << 9) + (n_ext << 7) + (n_ext << 3)
                 + (n_ext << 2) + (n_ext << 1) + n_ext;

    // Constant 1311 = 1024 + 256 + 16 + 8 + 4 + 2 + 1.
    assign p_two = (n_ext << 10) + (n_ext << 8) + (n_ext << 4)
                 + (n_ext << 3) + (n_ext << 2) + (n_ext << 1) + n_ext;

    // Pick the product named by the select code.
    always_comb begin
        unique case (margin_sel_e'(sel))
            MARGIN_NONE: p_sel = '0;
            MARGIN_HALF: p_sel = p_half;
            MARGIN_ONE:  p_sel = p_one;
            MARGIN_TWO:  p_sel = p_two;
            default:     p_sel = '0;
        endcase
    end

    // Drop the fraction bits.
    assign margin = DATA_W'(p_sel >> MARGIN_FRAC);

endmodule

// File: rtl/ogc_debounce.sv
// Module: ogc_debounce
// Asserts `hit` after `cond` has been sampled true on N consecutive edges,
// and holds it while `cond` stays true. Any false sample clears it.
// Assumes: N >= 1.
module ogc_debounce #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] run_cnt;

    // Count the current run of true samples and flag when it reaches N.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            hit     <= 1'b0;
        end else if (!cond) begin
            run_cnt <= '0;
            hit     <= 1'b0;
        end else if (!hit) begin
            if (run_cnt == LAST) begin
                hit <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ogc_gate_latch.sv
// Module: ogc_gate_latch
// Reset-dominant set/reset state for the switch, plus the gate output
// stage and sense-point select.
// Assumes: clr_req already contains every clearing path.
module ogc_gate_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic gate_dis,
    input  logic gate_pol,
    output logic gate_o,
    output logic sense_sel_o
);
    logic on_q;
    logic active;

    // Hold the switch state; clearing wins over setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
        end else if (clr_req) begin
            on_q <= 1'b0;
        end else if (set_req) begin
            on_q <= 1'b1;
        end
    end

    // Global disable overrides the stored state without waiting for an edge.
    assign active = on_q & ~gate_dis;

    // Push-pull drive: on maps to the programmed level, off to its inverse.
    assign gate_o      = gate_pol ? active : ~active;
    assign sense_sel_o = active;

endmodule

// File: rtl/oring_gate_ctrl.sv
// Module: oring_gate_ctrl (top)
// ORing switch gate controller: margin compare, debounced enable and
// reverse-current paths, masked fault gating and a reset-dominant latch.
// Assumes: all readings share one scale and are synchronous to clk.
module oring_gate_ctrl #(
    parameter int DATA_W = 12,
    parameter int FLT_W  = 8,
    parameter int DEB_N  = 4,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] supply_rd,
    input  logic [DATA_W-1:0] bus_rd,
    input  logic [DATA_W-1:0] nominal_rd,
    input  logic [1:0]        thr_sel,
    input  logic              rev_trip,
    input  logic              rev_en,
    input  logic [LVL_W-1:0]  rev_level,
    output logic [LVL_W-1:0]  rev_level_o,
    input  logic [FLT_W-1:0]  fault_flags,
    input  logic [FLT_W-1:0]  fault_off_mask,
    input  logic              gate_dis,
    input  logic              gate_pol,
    output logic              gate_o,
    output logic              sense_sel_o
);
    logic [DATA_W-1:0] margin;
    logic [DATA_W:0]   lifted;
    logic              fwd_ok;
    logic              fwd_hit;
    logic              rev_cond;
    logic              rev_hit;
    logic [FLT_W-1:0]  fault_act;
    logic              fault_any;
    logic              clr_req;

    // Margin from nominal and the select code.
    ogc_margin #(.DATA_W(DATA_W)) u_margin (
        .nominal (nominal_rd),
        .sel     (thr_sel),
        .margin  (margin)
    );

    // Converter side lifted by the margin must exceed the bus side.
    assign lifted = {1'b0, supply_rd} + {1'b0, margin};
    assign fwd_ok = lifted > {1'b0, bus_rd};

    // Debounce the enable condition.
    ogc_debounce #(.N(DEB_N)) u_fwd_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (fwd_ok),
        .hit   (fwd_hit)
    );

    // Reverse-current path, gated by its enable, then debounced.
    assign rev_cond = rev_trip & rev_en;

    ogc_debounce #(.N(DEB_N)) u_rev_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (rev_cond),
        .hit   (rev_hit)
    );

    // Per-flag action gating.
    genvar gi;
    generate
        for (gi = 0; gi < FLT_W; gi++) begin : g_fault
            assign fault_act[gi] = fault_flags[gi] & fault_off_mask[gi];
        end
    endgenerate

    assign fault_any = |fault_act;
    assign clr_req   = fault_any | rev_hit | gate_dis;

    // State latch and output stage.
    ogc_gate_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (fwd_hit),
        .clr_req     (clr_req),
        .gate_dis    (gate_dis),
        .gate_pol    (gate_pol),
        .gate_o      (gate_o),
        .sense_sel_o (sense_sel_o)
    );

    // Register the comparator level code toward the analog comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_level_o <= '0;
        end else begin
            rev_level_o <= rev_level;
        end
    end

endmodule

// File: rtl/ogc_checker.sv
// Module: ogc_checker
// Port-level temporal checks for oring_gate_ctrl, attached by bind.
// Assumes: the inputs are stable around clock edges.
module ogc_checker #(
    parameter int FLT_W = 8,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FLT_W-1:0] fault_flags,
    input logic [FLT_W-1:0] fault_off_mask,
    input logic             gate_dis,
    input logic             gate_pol,
    input logic [LVL_W-1:0] rev_level,
    input logic [LVL_W-1:0] rev_level_o,
    input logic             gate_o,
    input logic             sense_sel_o
);
    logic fault_seen;

    assign fault_seen = |(fault_flags & fault_off_mask);

    assert_fault_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_seen |=> (gate_o != gate_pol));

    assert_dis_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_dis |-> !sense_sel_o);

    assert_remote_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sense_sel_o |-> (gate_o == gate_pol));

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_sel_o) |-> !$past(fault_seen));

    assert_level_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rev_level_o == $past(rev_level)));

endmodule

bind oring_gate_ctrl ogc_checker #(.FLT_W(FLT_W), .LVL_W(LVL_W)) u_ogc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_flags    (fault_flags),
    .fault_off_mask (fault_off_mask),
    .gate_dis       (gate_dis),
    .gate_pol       (gate_pol),
    .rev_level      (rev_level),
    .rev_level_o    (rev_level_o),
    .gate_o         (gate_o),
    .sense_sel_o    (sense_sel_o)
);

// File: tb/oring_gate_ctrl_bench.sv
`timescale 1ns/1ps
module oring_gate_ctrl_bench;
    localparam int DATA_W = 12;
    localparam int FLT_W  = 8;
    localparam int DEB_N  = 4;
    localparam int LVL_W  = 3;
    localparam int NVEC   = 12;

    typedef struct packed {
        logic [11:0] nom;
        logic [11:0] sup;
        logic [11:0] bus;
        logic [1:0]  sel;
        logic        exp_on;
    } vec_t;

    // Margins: 3000 -> 15/29/60, 4000 sel 11 -> 80, 4095 sel 11 -> 81.
    localparam vec_t VECS [0:NVEC-1] = '{
        '{12'd3000, 12'd3000, 12'd3000, 2'b00, 1'b0},
        '{12'd3000, 12'd3001, 12'd3000, 2'b00, 1'b1},
        '{12'd3000, 12'd2985, 12'd3000, 2'b01, 1'b0},
        '{12'd3000, 12'd2986, 12'd3000, 2'b01, 1'b1},
        '{12'd3000, 12'd2971, 12'd3000, 2'b10, 1'b0},
        '{12'd3000, 12'd2972, 12'd3000, 2'b10, 1'b1},
        '{12'd3000, 12'd2940, 12'd3000, 2'b11, 1'b0},
        '{12'd3000, 12'd2941, 12'd3000, 2'b11, 1'b1},
        '{12'd4000, 12'd3921, 12'd4000, 2'b11, 1'b1},
        '{12'd4000, 12'd3920, 12'd4000, 2'b11, 1'b0},
        '{12'd0,    12'd10,   12'd10,   2'b11, 1'b0},
        '{12'd4095, 12'd100,  12'd181,  2'b11, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DATA_W-1:0] supply_rd, bus_rd, nominal_rd;
    logic [1:0]        thr_sel;
    logic              rev_trip, rev_en;
    logic [LVL_W-1:0]  rev_level, rev_level_o;
    logic [FLT_W-1:0]  fault_flags, fault_off_mask;
    logic              gate_dis, gate_pol;
    logic              gate_o, sense_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    oring_gate_ctrl #(.DATA_W(DATA_W), .FLT_W(FLT_W), .DEB_N(DEB_N), .LVL_W(LVL_W)) u_oring_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_rd(supply_rd), .bus_rd(bus_rd),
        .nominal_rd(nominal_rd), .thr_sel(thr_sel), .rev_trip(rev_trip),
        .rev_en(rev_en), .rev_level(rev_level), .rev_level_o(rev_level_o),
        .fault_flags(fault_flags), .fault_off_mask(fault_off_mask),
        .gate_dis(gate_dis), .gate_pol(gate_pol), .gate_o(gate_o),
        .sense_sel_o(sense_sel_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Switch on with active-high polarity: gate 1, remote sense.
    task automatic chk_state(input string req, input logic on);
        chk(req, {31'd0, gate_o}, {31'd0, on});
        chk(req, {31'd0, sense_sel_o}, {31'd0, on});
    endtask

    initial begin
        rst_n = 1'b0; supply_rd = '0; bus_rd = 12'd100; nominal_rd = 12'd3000;
        thr_sel = 2'b00; rev_trip = 1'b0; rev_en = 1'b0; rev_level = '0;
        fault_flags = '0; fault_off_mask = '0; gate_dis = 1'b0; gate_pol = 1'b1;
        tick(3);
        chk_state("R1 reset", 1'b0);
        gate_pol = 1'b0; #1;
        chk("R1 reset inactive low pol", {31'd0, gate_o}, 32'd1);
        gate_pol = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        tick(2);
        chk_state("R1 after release", 1'b0);

        // Vector table: margin compare across select codes (R2, R8).
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            gate_dis = 1'b1;
            nominal_rd = VECS[i].nom; supply_rd = VECS[i].sup;
            bus_rd = VECS[i].bus; thr_sel = VECS[i].sel;
            tick(DEB_N + 1);
            @(negedge clk) gate_dis = 1'b0;
            tick(1);
            chk_state($sformatf("R2 vector %0d", i), VECS[i].exp_on);
        end

        // Back to off with the enable condition false.
        @(negedge clk);
        gate_dis = 1'b1; nominal_rd = 12'd3000; thr_sel = 2'b00;
        supply_rd = '0; bus_rd = 12'd100;
        tick(2);
        @(negedge clk) gate_dis = 1'b0;
        tick(1);
        chk_state("R2 cleared", 1'b0);

        // R3: a short run restarts the count, a full run sets the latch.
        @(negedge clk) supply_rd = 12'd200;
        tick(DEB_N - 1);
        @(negedge clk) supply_rd = '0;
        tick(1);
        @(negedge clk) supply_rd = 12'd200;
        tick(DEB_N);
        chk_state("R3 not yet", 1'b0);
        tick(1);
        chk_state("R3 on", 1'b1);

        // R11: the latch holds after the condition drops.
        @(negedge clk) supply_rd = '0;
        tick(3);
        chk_state("R11 hold", 1'b1);
        @(negedge clk) supply_rd = 12'd200;
        tick(DEB_N + 1);

        // R4: masked and unmasked faults; R9: clear beats a live enable.
        @(negedge clk) begin fault_flags = 8'h01; fault_off_mask = 8'hFE; end
        tick(2);
        chk_state("R4 unmasked ignored", 1'b1);
        @(negedge clk) fault_off_mask = 8'h01;
        tick(1);
        chk_state("R4 fault off", 1'b0);
        tick(3);
        chk_state("R9 fault held over enable", 1'b0);
        @(negedge clk) fault_flags = 8'h00;
        tick(1);
        chk_state("R4 released", 1'b1);

        // R5: reverse-current path, disabled then enabled.
        @(negedge clk) begin rev_en = 1'b0; rev_trip = 1'b1; end
        tick(DEB_N + 3);
        chk_state("R5 ignored when disabled", 1'b1);
        @(negedge clk) rev_en = 1'b1;
        tick(DEB_N);
        chk_state("R5 not yet", 1'b1);
        tick(1);
        chk_state("R5 off", 1'b0);
        @(negedge clk) rev_trip = 1'b0;
        tick(1);
        chk_state("R5 first edge after release", 1'b0);
        tick(1);
        chk_state("R5 back on", 1'b1);

        // R7: polarity flips the drive level without a clock.
        @(negedge clk) gate_pol = 1'b0;
        #1;
        chk("R7 on low pol", {31'd0, gate_o}, 32'd0);
        chk("R7 sense on", {31'd0, sense_sel_o}, 32'd1);

        // R6: global disable acts at once and stays off.
        gate_dis = 1'b1;
        #1;
        chk("R6 gate inactive low pol", {31'd0, gate_o}, 32'd1);
        chk("R6 sense local", {31'd0, sense_sel_o}, 32'd0);
        gate_pol = 1'b1;
        tick(2);
        chk_state("R6 held", 1'b0);
        @(negedge clk) gate_dis = 1'b0;
        tick(1);
        chk_state("R6 released", 1'b1);

        // R10: level code passes through one register.
        @(negedge clk) rev_level = 3'd5;
        #1;
        chk("R10 before edge", {29'd0, rev_level_o}, 32'd0);
        tick(1);
        chk("R10 after edge", {29'd0, rev_level_o}, 32'd5);

        // R1: reset in the middle of a run clears the latch.
        @(negedge clk) rst_n = 1'b0;
        tick(1);
        chk_state("R1 mid-run reset", 1'b0);
        chk("R1 level reset", {29'd0, rev_level_o}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule